// File: doc/BRIEF.md
# ECC Step Status Summariser

After a page has been read through the BCH engine, that engine leaves one 64-bit status word for every ECC step. This block takes those words one at a time over a valid/ready stream. From them it builds the page-level result: the total number of corrected bits, the worst bitflip count seen in any one step, a bitmap of the steps that decoded, and one verdict for the whole page. The verdict tells the caller which of four things to do:

- use the data;
- hand back an all-0xFF page because the page is blank scrambled media;
- report an uncorrectable page;
- treat the page as not yet finished by the engine.

A page starts with a one-cycle `start` pulse, given while the block is idle. That pulse loads the step count, the ECC strength, the scrambling flag and a raw flag. The block then accepts exactly that many words and raises `done` for one cycle. In a raw read the engine was bypassed, so the block takes a single word and looks only at its completion bit. The two user bytes carried in each word are passed out, tagged with their step index, as each word is consumed.

Top module: `ecc_step_summary`

## Requirements
- R1: After reset, `st_ready`, `done`, `usr_valid` and `verdict` are 0, and `total_fixed`, `max_flips` and `ok_map` are 0.
- R2: A `start` pulse while idle does four things on the next edge: it loads the configuration, clears `total_fixed`, `max_flips` and `ok_map`, sets `verdict` to 0, and raises `st_ready`. A `start` while `st_ready` is high has no effect.
- R3: Status word fields are:
  - bit 31: completion;
  - bits 29:24: error count, where 63 means uncorrectable;
  - bits 21:16: zero-bit count;
  - bits 7:0: first user byte;
  - bits 15:8: second user byte.

  The cycle after a word is accepted, `usr_valid` is high, and `usr_lo`, `usr_hi` and `usr_step` carry that word's user bytes and step index.
- R4: A correctable step does three things: it adds its error count to `total_fixed`, raises `max_flips` to that count if the count is larger, and sets `ok_map` bit [step index]. While no word is accepted, these outputs hold.
- R5: An uncorrectable step counts as erased when scrambling is on and its zero count is strictly below the strength. An erased step adds its zero count to `total_fixed` and to the maximum, leaves its map bit clear, and sets `verdict` to 1 (fill with 0xFF).
- R6: An uncorrectable step that is not erased sets `verdict` to 2 (hard error) and changes none of the counters.
- R7: When a page has both erased and hard steps, the verdict is taken from the last uncorrectable step in the page.
- R8: If the final word of a page has bit 31 clear, `verdict` is 3 (incomplete). Bit 31 of earlier words is not checked.
- R9: In raw mode the block accepts one word whatever the step count. That word changes none of the counters or the map, and the verdict is 0 or 3 depending on its bit 31.
- R10: `done` is high for exactly the one cycle after the final word is accepted, and `st_ready` drops on the same edge. A `start` given during that `done` cycle is accepted.
- R11: Step counts from 1 to 64 are supported, with map bits 0 to 63. A step count of 0 is taken as 1, and a count above 64 is taken as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page (honoured only when idle) |
| cfg_steps | input | 7 | Number of ECC steps in the page |
| cfg_strength | input | 6 | ECC strength used as the erased threshold |
| cfg_scramble | input | 1 | Scrambling was enabled for this page |
| cfg_raw | input | 1 | ECC-bypassed read: one word, completion only |
| st_valid | input | 1 | Status word present |
| st_word | input | 64 | Status word for the current step |
| st_ready | output | 1 | Block is in a page and consumes words |
| done | output | 1 | One-cycle pulse after the final word |
| total_fixed | output | 12 | Sum of corrected and erased-step zero counts |
| max_flips | output | 6 | Largest per-step count contributing to the total |
| ok_map | output | 64 | One bit per step that decoded |
| verdict | output | 2 | 0 clean, 1 fill 0xFF, 2 hard error, 3 incomplete |
| usr_valid | output | 1 | User bytes of the word accepted last cycle are valid |
| usr_lo | output | 8 | First user byte of that step |
| usr_hi | output | 8 | Second user byte of that step |
| usr_step | output | 6 | Step index of those user bytes |

## Verification
Two events can fall in one cycle:

- A page's `done` pulse and the `start` of the next page. The bench starts the next page immediately after the last word of the previous one. The bench model is then compared every cycle, which shows that the results were cleared and `st_ready` rose again one edge after `done`.
- A word being accepted and a `start` pulse arriving. The bench raises `start` with a different configuration while words are flowing. The per-cycle comparison shows that the stray pulse changed neither the step count nor the totals.

// File: rtl/ecc_step_summary.sv
module ecc_step_summary #(
  parameter int STEPS_MAX = 64,
  localparam int SW = $clog2(STEPS_MAX + 1),
  localparam int IW = $clog2(STEPS_MAX),
  localparam int TW = $clog2(STEPS_MAX * 63 + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        cfg_steps,
  input  logic [5:0]           cfg_strength,
  input  logic                 cfg_scramble,
  input  logic                 cfg_raw,
  input  logic                 st_valid,
  input  logic [63:0]          st_word,
  output logic                 st_ready,
  output logic                 done,
  output logic [TW-1:0]        total_fixed,
  output logic [5:0]           max_flips,
  output logic [STEPS_MAX-1:0] ok_map,
  output logic [1:0]           verdict,
  output logic                 usr_valid,
  output logic [7:0]           usr_lo,
  output logic [7:0]           usr_hi,
  output logic [IW-1:0]        usr_step
);

  logic [SW-1:0] steps_q;
  logic [5:0]    str_q;
  logic          scr_q, raw_q, busy_q, cmpl_q;
  logic [IW-1:0] idx_q;
  logic [1:0]    cls_q;

  wire [5:0] err_cnt  = st_word[29:24];
  wire [5:0] zero_cnt = st_word[21:16];
  wire       accept   = busy_q & st_valid;
  wire       uncorr   = (err_cnt == 6'h3F);
  wire       erased   = uncorr & scr_q & (zero_cnt < str_q);
  wire [5:0] gain     = uncorr ? zero_cnt : err_cnt;
  wire       add      = ~raw_q & (~uncorr | erased);
  wire       last     = raw_q | ({1'b0, idx_q} == (SW + 1)'(steps_q - 1'b1));

  wire [SW-1:0] steps_in = (cfg_steps == '0) ? SW'(1) :
                           (cfg_steps > SW'(STEPS_MAX)) ? SW'(STEPS_MAX) : cfg_steps;

  assign st_ready = busy_q;
  assign verdict  = cmpl_q ? cls_q : 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steps_q     <= SW'(1);
      str_q       <= '0;
      scr_q       <= 1'b0;
      raw_q       <= 1'b0;
      busy_q      <= 1'b0;
      cmpl_q      <= 1'b1;
      idx_q       <= '0;
      cls_q       <= 2'd0;
      done        <= 1'b0;
      total_fixed <= '0;
      max_flips   <= '0;
      ok_map      <= '0;
      usr_valid   <= 1'b0;
      usr_lo      <= '0;
      usr_hi      <= '0;
      usr_step    <= '0;
    end else begin
      done      <= 1'b0;
      usr_valid <= 1'b0;
      if (!busy_q && start) begin
        steps_q     <= steps_in;
        str_q       <= cfg_strength;
        scr_q       <= cfg_scramble;
        raw_q       <= cfg_raw;
        busy_q      <= 1'b1;
        cmpl_q      <= 1'b1;
        idx_q       <= '0;
        cls_q       <= 2'd0;
        total_fixed <= '0;
        max_flips   <= '0;
        ok_map      <= '0;
      end else if (accept) begin
        usr_valid <= 1'b1;
        usr_lo    <= st_word[7:0];
        usr_hi    <= st_word[15:8];
        usr_step  <= idx_q;
        idx_q     <= idx_q + 1'b1;
        if (add) begin
          total_fixed <= total_fixed + TW'(gain);
          if (gain > max_flips) max_flips <= gain;
        end
        if (!raw_q) begin
          if (!uncorr) ok_map[idx_q] <= 1'b1;
          else         cls_q <= erased ? 2'd1 : 2'd2;
        end
        if (last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          cmpl_q <= st_word[31];
        end
      end
    end
  end

endmodule

// File: rtl/ecc_step_summary_chk.sv
module ecc_step_summary_chk #(
  parameter int STEPS_MAX = 64,
  parameter int TW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 raw,
  input logic                 st_valid,
  input logic [63:0]          st_word,
  input logic [TW-1:0]        total,
  input logic [5:0]           max_flips,
  input logic [STEPS_MAX-1:0] ok_map
);

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && total == '0 && max_flips == '0 && ok_map == '0));

  a_r4_hold_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !st_valid) |=> ($stable(total) && $stable(max_flips) && $stable(ok_map)));

  a_r4_max_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_valid && !raw && st_word[29:24] != 6'h3F) |=> (max_flips >= $past(st_word[29:24])));

  a_r9_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    raw |-> (total == '0 && ok_map == '0 && max_flips == '0));

endmodule

bind ecc_step_summary ecc_step_summary_chk #(.STEPS_MAX(STEPS_MAX), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .done(done), .raw(raw_q),
  .st_valid(st_valid), .st_word(st_word), .total(total_fixed), .max_flips(max_flips),
  .ok_map(ok_map)
);

// File: tb/ecc_step_summary_test.sv
module ecc_step_summary_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] cfg_steps = '0;
  logic [5:0] cfg_strength = '0;
  logic cfg_scramble = 1'b0, cfg_raw = 1'b0, st_valid = 1'b0;
  logic [63:0] st_word = '0;
  logic st_ready, done, usr_valid;
  logic [11:0] total_fixed;
  logic [5:0] max_flips, usr_step;
  logic [63:0] ok_map;
  logic [1:0] verdict;
  logic [7:0] usr_lo, usr_hi;

  always #5 clk = ~clk;

  ecc_step_summary uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_steps(cfg_steps),
    .cfg_strength(cfg_strength), .cfg_scramble(cfg_scramble), .cfg_raw(cfg_raw),
    .st_valid(st_valid), .st_word(st_word), .st_ready(st_ready), .done(done),
    .total_fixed(total_fixed), .max_flips(max_flips), .ok_map(ok_map),
    .verdict(verdict), .usr_valid(usr_valid), .usr_lo(usr_lo), .usr_hi(usr_hi),
    .usr_step(usr_step)
  );

  int vectors = 0, misses = 0, cyc = 0;
  bit running = 1'b0;

  // behavioural reference model
  bit m_busy, m_done, m_uv, m_scr, m_raw, m_cmpl;
  int m_steps, m_str, m_idx, m_total, m_max, m_cls, m_ustep;
  logic [63:0] m_map;
  logic [7:0] m_ulo, m_uhi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_uv = 0; m_cmpl = 1; m_cls = 0;
      m_total = 0; m_max = 0; m_map = '0; m_idx = 0; m_raw = 0;
      m_ulo = 0; m_uhi = 0; m_ustep = 0;
    end else begin
      m_done = 0; m_uv = 0;
      if (!m_busy && start) begin
        m_steps = (cfg_steps == 0) ? 1 : (cfg_steps > 64 ? 64 : int'(cfg_steps));
        m_str = cfg_strength; m_scr = cfg_scramble; m_raw = cfg_raw;
        m_busy = 1; m_cmpl = 1; m_idx = 0; m_cls = 0;
        m_total = 0; m_max = 0; m_map = '0;
      end else if (m_busy && st_valid) begin
        int e, z;
        e = st_word[29:24]; z = st_word[21:16];
        m_uv = 1; m_ulo = st_word[7:0]; m_uhi = st_word[15:8]; m_ustep = m_idx;
        if (!m_raw) begin
          if (e != 63) begin
            m_total += e; if (e > m_max) m_max = e; m_map[m_idx] = 1'b1;
          end else if (m_scr && z < m_str) begin
            m_total += z; if (z > m_max) m_max = z; m_cls = 1;
          end else m_cls = 2;
        end
        m_idx++;
        if (m_raw || m_idx == m_steps) begin
          m_busy = 0; m_done = 1; m_cmpl = st_word[31];
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint got, longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h at t=%0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(st_ready == m_busy, "R2", "st_ready", st_ready, m_busy);
      chk(done == m_done, "R10", "done", done, m_done);
      chk(total_fixed == m_total, "R4", "total_fixed", total_fixed, m_total);
      chk(max_flips == m_max, "R4", "max_flips", max_flips, m_max);
      chk(ok_map == m_map, "R4", "ok_map", ok_map, m_map);
      chk(verdict == (m_cmpl ? m_cls : 3), "R7", "verdict", verdict, m_cmpl ? m_cls : 3);
      chk(usr_valid == m_uv, "R3", "usr_valid", usr_valid, m_uv);
      if (m_uv)
        chk(usr_lo == m_ulo && usr_hi == m_uhi && usr_step == m_ustep, "R3", "user bytes",
            {usr_step, usr_hi, usr_lo}, {m_ustep[5:0], m_uhi, m_ulo});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      misses++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // kind: 0 correctable, 1 uncorrectable small zero, 2 uncorrectable large zero
  function automatic logic [63:0] mk(int kind, bit cmpl);
    logic [63:0] w;
    w = {32'h0, 16'h0, 8'($urandom), 8'($urandom)};
    w[31] = cmpl;
    w[23:22] = 2'($urandom);
    if (kind == 0) begin w[29:24] = 6'($urandom_range(0, 8)); w[21:16] = 6'($urandom); end
    else if (kind == 1) begin w[29:24] = 6'h3F; w[21:16] = 6'($urandom_range(0, 3)); end
    else begin w[29:24] = 6'h3F; w[21:16] = 6'($urandom_range(40, 63)); end
    return w;
  endfunction

  // mode: 0 all ok, 1 all erased-like, 2 all hard-like, 3 mixed, 4 erased..hard last, 5 hard..erased last
  task automatic page(int n, int str, bit scr, bit raw, int mode, bit drop, bit gap, bit stray);
    int cnt;
    cnt = raw ? 1 : (n == 0 ? 1 : (n > 64 ? 64 : n));
    start = 1; cfg_steps = 7'(n); cfg_strength = 6'(str); cfg_scramble = scr; cfg_raw = raw;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < cnt; i++) begin
      int k;
      if (gap && (i % 3 == 1)) begin st_valid = 0; @(negedge clk); end
      case (mode)
        0: k = 0;
        1: k = 1;
        2: k = 2;
        3: k = int'($urandom_range(0, 2));
        4: k = (i == cnt - 1) ? 2 : 1;
        default: k = (i == cnt - 1) ? 1 : 2;
      endcase
      st_valid = 1;
      st_word = mk(k, !(drop && i == cnt - 1));
      if (stray && i == 0) begin
        start = 1; cfg_steps = 7'd2; cfg_raw = 1; cfg_scramble = ~scr;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    st_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(st_ready == 0 && done == 0 && usr_valid == 0 && verdict == 0 &&
        total_fixed == 0 && max_flips == 0 && ok_map == 0, "R1", "reset state",
        {st_ready, done, usr_valid, verdict, total_fixed, max_flips}, 0);
    rst_n = 1;
    running = 1;
    @(negedge clk);

    page(1, 8, 0, 0, 0, 0, 0, 0);
    page(4, 8, 0, 0, 0, 0, 1, 0);
    page(8, 8, 1, 0, 1, 0, 0, 0);
    chk(verdict == 1, "R5", "erased verdict", verdict, 1);
    page(8, 8, 0, 0, 1, 0, 0, 0);
    chk(verdict == 2, "R6", "no-scramble verdict", verdict, 2);
    page(6, 8, 1, 0, 2, 0, 0, 0);
    chk(verdict == 2 && total_fixed == 0, "R6", "hard verdict", {total_fixed, verdict}, 2);
    page(5, 8, 1, 0, 4, 0, 0, 0);
    chk(verdict == 2, "R7", "hard last wins", verdict, 2);
    page(5, 8, 1, 0, 5, 0, 0, 0);
    chk(verdict == 1, "R7", "erased last wins", verdict, 1);
    page(4, 8, 0, 0, 0, 1, 0, 0);
    chk(verdict == 3, "R8", "incomplete verdict", verdict, 3);
    page(3, 8, 0, 1, 0, 0, 0, 0);
    chk(verdict == 0 && total_fixed == 0 && ok_map == 0, "R9", "raw clean",
        {verdict, total_fixed}, 0);
    page(3, 8, 0, 1, 2, 1, 0, 0);
    chk(verdict == 3, "R9", "raw incomplete", verdict, 3);
    page(64, 8, 0, 0, 0, 0, 0, 0);
    chk(ok_map == '1, "R11", "64-step map", ok_map, 64'hFFFF_FFFF_FFFF_FFFF);
    page(0, 8, 0, 0, 0, 0, 0, 0);
    chk(ok_map == 64'h1, "R11", "zero steps as one", ok_map, 1);
    page(10, 8, 0, 0, 0, 0, 0, 1);
    for (int r = 0; r < 40; r++)
      page(int'($urandom_range(1, 64)), int'($urandom_range(1, 20)), 1'($urandom),
           1'($urandom_range(0, 7) == 0), 3, 1'($urandom_range(0, 5) == 0),
           1'($urandom), 1'($urandom_range(0, 4) == 0));
    repeat (3) @(negedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule